// File: doc/BRIEF.md
# Relative Branch Condition Evaluator

This block decides, for an 8-bit microcontroller core, whether a conditional relative branch is taken and which program counter comes next. The core presents one instruction per valid cycle: the opcode byte, a flag marking an opcode that came after a prefix byte, the condition-code flags, the level of the external interrupt pin, the address of the instruction, its signed 8-bit displacement and, for the bit-test forms, the memory byte being tested. One clock later the block returns a registered result. The result holds the taken decision, the next PC, the number of cycles the instruction costs, an illegal-opcode flag, and the condition-code flags passed through unchanged.

Two families of branch are handled. Short branches occupy two bytes and take 3 cycles. Their conditions look at the carry, zero, negative, overflow and interrupt-mask flags, or at the interrupt pin. Bit-test branches occupy three bytes and take 5 cycles. They select one bit of the memory operand and branch on its value. Fetching, memory access and flag updates belong to the rest of the core.

Top module: `relbr_eval`

## Requirements
- R1: Results appear on the outputs one clock after the instruction is presented with in_valid high, and out_valid is high exactly in the cycle after a cycle with in_valid high. Synchronous reset clears out_valid, taken and illegal.
- R2: For a legal short branch, next_pc is cur_pc + 2 + sign-extended disp when taken and cur_pc + 2 when not taken. All sums wrap modulo 2^16.
- R3: cycles reads 3 for a legal short branch and 5 for a legal bit-test branch.
- R4: Opcode 0x20 is always taken and 0x21 is never taken. 0x26 is taken when Z = 0, 0x2A when N = 0, and 0x2B when N = 1.
- R5: Opcode 0x24 is taken when C = 0, 0x25 when C = 1, and 0x23 when C or Z is 1.
- R6: Opcode 0x2C is taken when I = 0 and 0x2D when I = 1. 0x2F is taken when irq_pin is 1 and 0x2E when it is 0.
- R7: Opcode 0x91 is taken when N xor V is 1. Opcode 0x93 is taken when Z or (N xor V) is 1.
- R8: Opcodes 0x00 to 0x0F are bit-test branches on bit opcode[3:1] of mem_operand. With opcode[0] = 0 the branch is taken when that bit is 1; with opcode[0] = 1 it is taken when the bit is 0.
- R9: For a bit-test branch, next_pc is cur_pc + 3 + sign-extended disp when taken and cur_pc + 3 when not, wrapping modulo 2^16.
- R10: ccr_out equals the ccr_in presented with the instruction. The flag vector is laid out as bit 0 C, bit 1 Z, bit 2 N, bit 3 I, bit 4 V.
- R11: Any other opcode, and any opcode with prefixed = 1, gives illegal = 1, taken = 0, next_pc = cur_pc and cycles = 0. Legal opcodes give illegal = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| opcode | input | 8 | Opcode byte |
| prefixed | input | 1 | Opcode followed a prefix byte |
| ccr_in | input | 5 | Condition flags {V,I,N,Z,C} |
| irq_pin | input | 1 | Level of the external interrupt pin |
| cur_pc | input | 16 | Address of the branch instruction |
| disp | input | 8 | Signed displacement |
| mem_operand | input | 8 | Memory byte tested by bit-test branches |
| out_valid | output | 1 | Result registers hold a new result |
| taken | output | 1 | Branch is taken |
| illegal | output | 1 | Opcode is not a recognised branch |
| next_pc | output | 16 | Address of the next instruction |
| cycles | output | 3 | Cycle cost of the instruction |
| ccr_out | output | 5 | Flags, unchanged |

## Verification
The bench walks every short-branch opcode through all 32 flag combinations with both pin levels, so a condition wired to the wrong flag or with its sense inverted shows up as a wrong taken bit. It drives every bit-test opcode with single-bit and all-ones or all-zeros operands. A design with the bit index or the polarity taken from the wrong opcode bit would branch on a neighbouring bit. Displacements of 0x80 and 0xFF and PCs near 0xFFFF aim at a zero-extended displacement or a missing wrap, and would give a target off by 256 or beyond 16 bits. Prefixed legal opcodes and unlisted opcodes catch a decoder that ignores the prefix or lets an unknown opcode drive taken.

// File: rtl/relbr_pkg.sv
package relbr_pkg;

  localparam int FLAG_W = 5;
  localparam int FLG_C  = 0;
  localparam int FLG_Z  = 1;
  localparam int FLG_N  = 2;
  localparam int FLG_I  = 3;
  localparam int FLG_V  = 4;

  typedef enum logic [3:0] {
    BC_ALWAYS,
    BC_NEVER,
    BC_ZCLR,
    BC_NCLR,
    BC_NSET,
    BC_CCLR,
    BC_CSET,
    BC_CORZ,
    BC_ICLR,
    BC_ISET,
    BC_PINHI,
    BC_PINLO,
    BC_SLT,
    BC_SLE,
    BC_BITTST,
    BC_NONE
  } bcls_e;

  typedef struct packed {
    bcls_e      cls;
    logic [2:0] bitsel;
    logic       want_one;
    logic       long_form;
    logic       legal;
  } bdec_t;

endpackage

// File: rtl/relbr_decode.sv
module relbr_decode
  import relbr_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic       prefixed,
  output bdec_t      dec
);

  always_comb begin
    dec           = '0;
    dec.cls       = BC_NONE;
    dec.bitsel    = opcode[3:1];
    dec.want_one  = ~opcode[0];
    dec.long_form = 1'b0;
    if (!prefixed) begin
      if (opcode[7:4] == 4'h0) begin
        dec.cls       = BC_BITTST;
        dec.long_form = 1'b1;
      end else begin
        case (opcode)
          8'h20:   dec.cls = BC_ALWAYS;
          8'h21:   dec.cls = BC_NEVER;
          8'h23:   dec.cls = BC_CORZ;
          8'h24:   dec.cls = BC_CCLR;
          8'h25:   dec.cls = BC_CSET;
          8'h26:   dec.cls = BC_ZCLR;
          8'h2A:   dec.cls = BC_NCLR;
          8'h2B:   dec.cls = BC_NSET;
          8'h2C:   dec.cls = BC_ICLR;
          8'h2D:   dec.cls = BC_ISET;
          8'h2E:   dec.cls = BC_PINLO;
          8'h2F:   dec.cls = BC_PINHI;
          8'h91:   dec.cls = BC_SLT;
          8'h93:   dec.cls = BC_SLE;
          default: dec.cls = BC_NONE;
        endcase
      end
    end
    dec.legal = (dec.cls != BC_NONE);
  end

endmodule

// File: rtl/relbr_cond.sv
module relbr_cond
  import relbr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  bcls_e              cls,
  input  logic [FLAG_W-1:0]  flags,
  input  logic               irq_pin,
  input  logic [DATA_W-1:0]  mem,
  input  logic [2:0]         bitsel,
  input  logic               want_one,
  output logic               cond
);

  localparam int SEL_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [DATA_W-1:0] hit;
  logic [SEL_W-1:0]  idx;
  logic              picked;
  logic              lt_signed;

  assign idx = SEL_W'(bitsel);

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_pick
      assign hit[gi] = mem[gi] & (idx == SEL_W'(gi));
    end
  endgenerate

  assign picked    = |hit;
  assign lt_signed = flags[FLG_N] ^ flags[FLG_V];

  always_comb begin
    case (cls)
      BC_ALWAYS: cond = 1'b1;
      BC_NEVER:  cond = 1'b0;
      BC_ZCLR:   cond = ~flags[FLG_Z];
      BC_NCLR:   cond = ~flags[FLG_N];
      BC_NSET:   cond = flags[FLG_N];
      BC_CCLR:   cond = ~flags[FLG_C];
      BC_CSET:   cond = flags[FLG_C];
      BC_CORZ:   cond = flags[FLG_C] | flags[FLG_Z];
      BC_ICLR:   cond = ~flags[FLG_I];
      BC_ISET:   cond = flags[FLG_I];
      BC_PINHI:  cond = irq_pin;
      BC_PINLO:  cond = ~irq_pin;
      BC_SLT:    cond = lt_signed;
      BC_SLE:    cond = flags[FLG_Z] | lt_signed;
      BC_BITTST: cond = (picked == want_one);
      default:   cond = 1'b0;
    endcase
  end

endmodule

// File: rtl/relbr_target.sv
module relbr_target #(
  parameter int PC_W    = 16,
  parameter int DISP_W  = 8,
  parameter int SHORT_L = 2,
  parameter int LONG_L  = 3
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [DISP_W-1:0] disp,
  input  logic              long_form,
  input  logic              legal,
  input  logic              cond,
  output logic [PC_W-1:0]   next_pc
);

  logic [PC_W-1:0] disp_ext;
  logic [PC_W-1:0] step;
  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] jump_pc;

  generate
    if (PC_W > DISP_W) begin : g_sext
      assign disp_ext = {{(PC_W-DISP_W){disp[DISP_W-1]}}, disp};
    end else begin : g_trunc
      assign disp_ext = disp[PC_W-1:0];
    end
  endgenerate

  assign step    = long_form ? PC_W'(LONG_L) : PC_W'(SHORT_L);
  assign seq_pc  = pc + step;
  assign jump_pc = seq_pc + disp_ext;

  always_comb begin
    if (!legal)     next_pc = pc;
    else if (cond)  next_pc = jump_pc;
    else            next_pc = seq_pc;
  end

endmodule

// File: rtl/relbr_eval.sv
module relbr_eval
  import relbr_pkg::*;
#(
  parameter int PC_W      = 16,
  parameter int DISP_W    = 8,
  parameter int DATA_W    = 8,
  parameter int CYC_W     = 3,
  parameter int SHORT_CYC = 3,
  parameter int LONG_CYC  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        opcode,
  input  logic              prefixed,
  input  logic [FLAG_W-1:0] ccr_in,
  input  logic              irq_pin,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [DISP_W-1:0] disp,
  input  logic [DATA_W-1:0] mem_operand,
  output logic              out_valid,
  output logic              taken,
  output logic              illegal,
  output logic [PC_W-1:0]   next_pc,
  output logic [CYC_W-1:0]  cycles,
  output logic [FLAG_W-1:0] ccr_out
);

  bdec_t           dec;
  logic            cond;
  logic            take_c;
  logic [PC_W-1:0] npc_c;
  logic [CYC_W-1:0] cyc_c;

  relbr_decode u_dec (
    .opcode   (opcode),
    .prefixed (prefixed),
    .dec      (dec)
  );

  relbr_cond #(.DATA_W(DATA_W)) u_cond (
    .cls      (dec.cls),
    .flags    (ccr_in),
    .irq_pin  (irq_pin),
    .mem      (mem_operand),
    .bitsel   (dec.bitsel),
    .want_one (dec.want_one),
    .cond     (cond)
  );

  assign take_c = cond & dec.legal;

  relbr_target #(.PC_W(PC_W), .DISP_W(DISP_W)) u_tgt (
    .pc        (cur_pc),
    .disp      (disp),
    .long_form (dec.long_form),
    .legal     (dec.legal),
    .cond      (take_c),
    .next_pc   (npc_c)
  );

  always_comb begin
    if (!dec.legal)        cyc_c = '0;
    else if (dec.long_form) cyc_c = CYC_W'(LONG_CYC);
    else                   cyc_c = CYC_W'(SHORT_CYC);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      taken     <= 1'b0;
      illegal   <= 1'b0;
      next_pc   <= '0;
      cycles    <= '0;
      ccr_out   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        taken   <= take_c;
        illegal <= ~dec.legal;
        next_pc <= npc_c;
        cycles  <= cyc_c;
        ccr_out <= ccr_in;
      end
    end
  end

endmodule

// File: rtl/relbr_eval_chk.sv
module relbr_eval_chk #(
  parameter int PC_W      = 16,
  parameter int CYC_W     = 3,
  parameter int SHORT_CYC = 3,
  parameter int LONG_CYC  = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [7:0]       opcode,
  input logic             prefixed,
  input logic [4:0]       ccr_in,
  input logic [PC_W-1:0]  cur_pc,
  input logic             out_valid,
  input logic             taken,
  input logic             illegal,
  input logic [PC_W-1:0]  next_pc,
  input logic [CYC_W-1:0] cycles,
  input logic [4:0]       ccr_out
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && !taken && !illegal));

  p_valid_follow_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_fallthru_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !prefixed && opcode[7:4] != 4'h0) |=>
      (illegal || taken || next_pc == $past(cur_pc) + PC_W'(2)));

  p_cycle_set_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !illegal) |->
      (cycles == CYC_W'(SHORT_CYC) || cycles == CYC_W'(LONG_CYC)));

  p_always_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !prefixed && opcode == 8'h20) |=> (taken && !illegal));

  p_never_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !prefixed && opcode == 8'h21) |=> (!taken && !illegal));

  p_flags_kept_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (ccr_out == $past(ccr_in)));

  p_illegal_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && illegal) |-> (!taken && cycles == '0));

  p_prefix_illegal_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && prefixed) |=> (illegal && next_pc == $past(cur_pc)));

endmodule

bind relbr_eval relbr_eval_chk #(
  .PC_W(PC_W), .CYC_W(CYC_W), .SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
  .prefixed(prefixed), .ccr_in(ccr_in), .cur_pc(cur_pc),
  .out_valid(out_valid), .taken(taken), .illegal(illegal),
  .next_pc(next_pc), .cycles(cycles), .ccr_out(ccr_out)
);

// File: tb/relbr_eval_test.sv
module relbr_eval_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [7:0]  opcode;
  logic        prefixed;
  logic [4:0]  ccr_in;
  logic        irq_pin;
  logic [15:0] cur_pc;
  logic [7:0]  disp;
  logic [7:0]  mem_operand;
  logic        out_valid;
  logic        taken;
  logic        illegal;
  logic [15:0] next_pc;
  logic [2:0]  cycles;
  logic [4:0]  ccr_out;

  int n_cmp  = 0;
  int n_fail = 0;

  bit         e_live = 0;
  bit         e_taken, e_ill;
  bit [15:0]  e_npc;
  bit [2:0]   e_cyc;
  bit [4:0]   e_ccr;
  string      e_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  relbr_eval uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
    .prefixed(prefixed), .ccr_in(ccr_in), .irq_pin(irq_pin),
    .cur_pc(cur_pc), .disp(disp), .mem_operand(mem_operand),
    .out_valid(out_valid), .taken(taken), .illegal(illegal),
    .next_pc(next_pc), .cycles(cycles), .ccr_out(ccr_out)
  );

  function automatic void model(input bit [7:0] op, input bit pre, input bit [4:0] f,
                                input bit irq, input bit [15:0] pc, input bit [7:0] d,
                                input bit [7:0] m, output bit t, output bit ill,
                                output bit [15:0] npc, output bit [2:0] cy, output string tag);
    bit c = f[0], z = f[1], n = f[2], i = f[3], v = f[4];
    int len;
    int sd;
    ill = 0; t = 0; len = 2; cy = 3;
    if (pre) begin
      ill = 1; tag = "R11";
    end else if (op < 8'h10) begin
      len = 3; cy = 5; tag = "R8";
      t = op[0] ? (m[op[3:1]] == 1'b0) : (m[op[3:1]] == 1'b1);
    end else begin
      case (op)
        8'h20: begin t = 1;          tag = "R4"; end
        8'h21: begin t = 0;          tag = "R4"; end
        8'h26: begin t = (z == 0);   tag = "R4"; end
        8'h2A: begin t = (n == 0);   tag = "R4"; end
        8'h2B: begin t = (n == 1);   tag = "R4"; end
        8'h24: begin t = (c == 0);   tag = "R5"; end
        8'h25: begin t = (c == 1);   tag = "R5"; end
        8'h23: begin t = c || z;     tag = "R5"; end
        8'h2C: begin t = (i == 0);   tag = "R6"; end
        8'h2D: begin t = (i == 1);   tag = "R6"; end
        8'h2F: begin t = (irq == 1); tag = "R6"; end
        8'h2E: begin t = (irq == 0); tag = "R6"; end
        8'h91: begin t = (n != v);   tag = "R7"; end
        8'h93: begin t = z || (n != v); tag = "R7"; end
        default: begin ill = 1;      tag = "R11"; end
      endcase
    end
    sd = (d >= 8'd128) ? int'(d) - 256 : int'(d);
    if (ill) begin
      t = 0; cy = 0; npc = pc;
    end else if (t) begin
      npc = 16'((int'(pc) + len + sd) & 32'hFFFF);
    end else begin
      npc = 16'((int'(pc) + len) & 32'hFFFF);
    end
  endfunction

  task automatic compare_prev();
    n_cmp++;
    if (!e_live) begin
      if (out_valid !== 1'b0) begin
        n_fail++;
        $display("FAIL R1 idle: out_valid=%0b expected 0", out_valid);
      end
    end else if (out_valid !== 1'b1 || taken !== e_taken || illegal !== e_ill ||
                 next_pc !== e_npc || cycles !== e_cyc || ccr_out !== e_ccr) begin
      n_fail++;
      $display("FAIL %s: v=%0b t=%0b ill=%0b npc=%h cyc=%0d ccr=%h expected v=1 t=%0b ill=%0b npc=%h cyc=%0d ccr=%h",
               e_tag, out_valid, taken, illegal, next_pc, cycles, ccr_out,
               e_taken, e_ill, e_npc, e_cyc, e_ccr);
    end
  endtask

  task automatic apply(input bit [7:0] op, input bit pre, input bit [4:0] f, input bit irq,
                       input bit [15:0] pc, input bit [7:0] d, input bit [7:0] m,
                       input string tagov);
    string t;
    @(negedge clk);
    compare_prev();
    in_valid = 1; opcode = op; prefixed = pre; ccr_in = f; irq_pin = irq;
    cur_pc = pc; disp = d; mem_operand = m;
    model(op, pre, f, irq, pc, d, m, e_taken, e_ill, e_npc, e_cyc, t);
    e_ccr  = f;
    e_live = 1;
    e_tag  = (tagov != "") ? tagov : t;
  endtask

  task automatic idle();
    @(negedge clk);
    compare_prev();
    in_valid = 0;
    opcode   = 8'h20;
    e_live   = 0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

  initial begin
    bit [7:0] shorts [14] = '{8'h20, 8'h21, 8'h23, 8'h24, 8'h25, 8'h26, 8'h2A,
                              8'h2B, 8'h2C, 8'h2D, 8'h2E, 8'h2F, 8'h91, 8'h93};
    rst = 1; in_valid = 1; opcode = 8'h20; prefixed = 0; ccr_in = 5'h1F;
    irq_pin = 0; cur_pc = 16'h1234; disp = 8'h10; mem_operand = 0;
    repeat (3) @(negedge clk);
    n_cmp++;  // R1 reset state
    if (out_valid !== 0 || taken !== 0 || illegal !== 0) begin
      n_fail++;
      $display("FAIL R1 reset: v=%0b t=%0b ill=%0b expected 0 0 0", out_valid, taken, illegal);
    end
    rst = 0; in_valid = 0;
    e_live = 0;

    // every short branch under all flag and pin combinations (R4 R5 R6 R7, cycles R3)
    foreach (shorts[k]) begin
      for (int f = 0; f < 32; f++) begin
        for (int p = 0; p < 2; p++) begin
          apply(shorts[k], 0, 5'(f), p[0], 16'h4000 + 16'(f), 8'(f * 7 + 3), 8'h00, "");
        end
      end
    end
    idle();

    // bit-test branches: every opcode, single-bit and full operands (R8 R9 R3)
    for (int op = 0; op < 16; op++) begin
      for (int b = 0; b < 10; b++) begin
        bit [7:0] m;
        m = (b < 8) ? 8'(1 << b) : ((b == 8) ? 8'h00 : 8'hFF);
        apply(8'(op), 0, 5'h0A, 0, 16'h8000 + 16'(b), 8'hF0, m, "");
      end
    end

    // wrap and sign extension (R2 R9)
    apply(8'h20, 0, 0, 0, 16'hFFFF, 8'h01, 0, "R2");
    apply(8'h20, 0, 0, 0, 16'h0001, 8'h80, 0, "R2");
    apply(8'h21, 0, 0, 0, 16'hFFFF, 8'h7F, 0, "R2");
    apply(8'h26, 0, 0, 0, 16'h0100, 8'hFF, 0, "R2");
    apply(8'h01, 0, 0, 0, 16'hFFFE, 8'hFE, 8'h00, "R9");
    apply(8'h0E, 0, 0, 0, 16'hFFFD, 8'h05, 8'h80, "R9");
    apply(8'h0F, 0, 0, 0, 16'hFFFE, 8'h05, 8'h80, "R9");
    idle();
    idle();

    // flags pass through unchanged (R10)
    apply(8'h20, 0, 5'h15, 1, 16'h0200, 8'h02, 8'h55, "R10");
    apply(8'h03, 0, 5'h0A, 0, 16'h0300, 8'h02, 8'hAA, "R10");

    // illegal and prefixed opcodes (R11)
    apply(8'h20, 1, 5'h00, 0, 16'h1000, 8'h10, 0, "R11");
    apply(8'h00, 1, 5'h00, 0, 16'h1001, 8'h10, 8'hFF, "R11");
    apply(8'h91, 1, 5'h04, 0, 16'h1002, 8'h10, 0, "R11");
    apply(8'h22, 0, 5'h00, 0, 16'h1003, 8'h10, 0, "R11");
    apply(8'h92, 0, 5'h00, 0, 16'h1004, 8'h10, 0, "R11");
    apply(8'hFF, 0, 5'h1F, 1, 16'h1005, 8'h10, 0, "R11");
    idle();

    // mixed random traffic with idle gaps (R1 and all decode paths)
    for (int r = 0; r < 1500; r++) begin
      bit [7:0] op;
      op = (r % 3 == 0) ? 8'($urandom_range(0, 15)) :
           (r % 3 == 1) ? shorts[$urandom_range(0, 13)] : 8'($urandom);
      if ($urandom_range(0, 7) == 0) idle();
      else apply(op, ($urandom_range(0, 15) == 0), 5'($urandom), 1'($urandom),
                 16'($urandom), 8'($urandom), 8'($urandom), "");
    end
    idle();
    idle();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

endmodule